// File: doc/BRIEF.md
# Two-Channel DMA Operation Control and Arbiter

This block combines the global operation register of a two-channel DMA controller with the arbiter that register steers. Software reaches the register through a 32-bit single-register slave port. The register holds a priority-mode selector, an interrupt enable and two sticky flags. One flag records a DMA address error and the other records a non-maskable interrupt. While either flag is set, no new channel is granted.

The arbiter takes a request and an enable for each channel. It issues a registered one-hot grant and holds that grant until the transfer-done strobe arrives. In fixed mode channel 0 always wins a tie. In rotating mode channel 1 leads after reset, and each completed transfer sends the channel that was served to the bottom of the order.

A full-standby input clears the register and the arbiter. A module-standby input pauses new grants and leaves every register bit as it was. The interrupt output is the enable bit combined with either flag.

Top module: `dma_op_ctrl`

## Requirements
- R1: Read data bit 3 is the priority mode (1 = rotating), bit 2 the address-error flag, bit 1 the NMI flag and bit 0 the interrupt enable; bits 31 to 4 always read 0 and writing them has no effect.
- R2: Asynchronous reset and a cycle of `stby_full` both clear the register to zero, drop any grant and return the rotating order to channel 1 first.
- R3: With priority mode 0, when both channels are eligible, channel 0 is granted (`ch_gnt` = 2'b01).
- R4: With priority mode 1, the first grant after reset or full standby goes to channel 1 when both are eligible; after each done strobe the served channel becomes lowest priority.
- R5: While `stby_mod` is high no new grant is issued, and the priority mode bit keeps its value through it.
- R6: An `addr_err` pulse sets the address-error flag; while it is 1 no channel is granted, whatever its enable.
- R7: A grant already active when the address error arrives stays until its done strobe; only later grants are blocked.
- R8: A flag clears only when a write carries 0 in its bit and the last register access before that write was a read that returned 1 in that bit; any write disarms this; writing 1 never sets a flag.
- R9: An `nmi_pulse` sets the NMI flag, which blocks new grants in the same way as the address-error flag.
- R10: A channel is granted only when its request and enable are both high; `ch_gnt` is at most one-hot and stays stable from grant until `xfer_done`, even if the request is withdrawn.
- R11: `err_irq` is high exactly when the interrupt enable is 1 and either flag is 1.
- R12: When a flag-setting event and an armed clearing write land in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_full | input | 1 | Full standby: synchronous clear of register and arbiter |
| stby_mod | input | 1 | Module standby: pauses new grants, keeps register |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| addr_err | input | 1 | Address-error event pulse |
| nmi_pulse | input | 1 | NMI event pulse |
| ch_req | input | 2 | Per-channel transfer request |
| ch_en | input | 2 | Per-channel enable |
| xfer_done | input | 1 | Done strobe for the granted transfer |
| ch_gnt | output | 2 | One-hot channel grant |
| err_irq | output | 1 | Error interrupt request |

## Verification
Two pairs of functions can meet in the same cycle. The first is a flag-setting event and the software clearing write. The bench arms the address-error marker with a read, then drives `addr_err` in the same cycle as a write of 0. It expects a read-back of 4, meaning the set wins. The second is an error event arriving while a transfer is granted. The bench pulses `addr_err` mid-transfer and checks that the grant survives until `xfer_done` and that the requests still pending get no grant afterwards.

// File: rtl/dmaop_pkg.sv
package dmaop_pkg;
  localparam int unsigned NCH      = 2;
  localparam int unsigned BIT_IE   = 0;
  localparam int unsigned FLAG_LSB = 1;  // bit1 NMI flag, bit2 address-error flag
  localparam int unsigned NFLAG    = 2;
  localparam int unsigned BIT_PR   = 3;
  localparam int unsigned IMPL_W   = 4;

  typedef enum logic [NFLAG-1:0] {
    FL_NMI = 2'd0,
    FL_AE  = 2'd1
  } flag_idx_e;
endpackage

// File: rtl/dmaop_reg.sv
module dmaop_reg
  import dmaop_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stby,
  input  logic             sel,
  input  logic             wr,
  input  logic [DW-1:0]    wdata,
  input  logic [NFLAG-1:0] flag_evt,
  output logic [DW-1:0]    rdata,
  output logic             pr,
  output logic             ie,
  output logic [NFLAG-1:0] flag
);
  localparam int unsigned PAD_W = DW - IMPL_W;

  logic rd_en, wr_en;
  logic pr_q, pr_d, ie_q, ie_d;
  logic [NFLAG-1:0] flag_q, flag_d, arm_q, arm_d;
  logic unused_hi;

  assign rd_en     = sel && !wr;
  assign wr_en     = sel && wr;
  assign unused_hi = ^wdata[DW-1:IMPL_W];

  always_comb begin
    pr_d = pr_q;
    ie_d = ie_q;
    if (stby) begin
      pr_d = 1'b0;
      ie_d = 1'b0;
    end else if (wr_en) begin
      pr_d = wdata[BIT_PR];
      ie_d = wdata[BIT_IE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pr_q <= 1'b0;
      ie_q <= 1'b0;
    end else begin
      pr_q <= pr_d;
      ie_q <= ie_d;
    end
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_comb begin
      flag_d[i] = flag_q[i];
      arm_d[i]  = arm_q[i];
      if (stby) begin
        flag_d[i] = 1'b0;
        arm_d[i]  = 1'b0;
      end else begin
        if (flag_evt[i])
          flag_d[i] = 1'b1;
        else if (wr_en && !wdata[FLAG_LSB+i] && arm_q[i])
          flag_d[i] = 1'b0;
        if (wr_en)
          arm_d[i] = 1'b0;
        else if (rd_en && flag_q[i])
          arm_d[i] = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
        arm_q[i]  <= 1'b0;
      end else begin
        flag_q[i] <= flag_d[i];
        arm_q[i]  <= arm_d[i];
      end
    end

    // R8: a flag never rises without its event
    p_no_write_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q[i] && !flag_evt[i]) |=> !flag_q[i]);
    // R12: an event always leaves the flag set
    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_evt[i] && !stby) |=> flag_q[i]);
  end

  assign rdata = {{PAD_W{1'b0}}, pr_q, flag_q[FL_AE], flag_q[FL_NMI], ie_q};
  assign pr    = pr_q;
  assign ie    = ie_q;
  assign flag  = flag_q;

  // R5: priority mode only moves on a write or full standby
  p_pr_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !stby) |=> $stable(pr_q));
endmodule

// File: rtl/dmaop_arb.sv
module dmaop_arb
  import dmaop_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stby,
  input  logic           hold,
  input  logic           block,
  input  logic           pr,
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] en,
  input  logic           done,
  output logic [NCH-1:0] gnt
);
  logic [NCH-1:0] gnt_q, gnt_d, cand, pick;
  logic           top_q, top_d;   // index of the channel on top in rotating mode
  logic           busy;

  assign cand = req & en;
  assign busy = |gnt_q;

  always_comb begin
    pick = '0;
    if (!pr) begin
      if (cand[0])      pick = 2'b01;
      else if (cand[1]) pick = 2'b10;
    end else begin
      if (cand[top_q])       pick = top_q  ? 2'b10 : 2'b01;
      else if (cand[!top_q]) pick = !top_q ? 2'b10 : 2'b01;
    end
  end

  always_comb begin
    gnt_d = gnt_q;
    top_d = top_q;
    if (stby) begin
      gnt_d = '0;
      top_d = 1'b1;
    end else if (busy) begin
      if (done) begin
        gnt_d = '0;
        if (pr) top_d = !gnt_q[1];
      end
    end else if (!block && !hold) begin
      gnt_d = pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q <= '0;
      top_q <= 1'b1;
    end else begin
      gnt_q <= gnt_d;
      top_q <= top_d;
    end
  end

  assign gnt = gnt_q;

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !stby) |=> $stable(gnt_q));
  p_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (block && !busy) |=> (gnt_q == '0));
  p_pause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !busy) |=> (gnt_q == '0));
  p_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pr && !busy && !block && !hold && !stby && cand[0]) |=> (gnt_q == 2'b01));
endmodule

// File: rtl/dma_op_ctrl.sv
module dma_op_ctrl
  import dmaop_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stby_full,
  input  logic          stby_mod,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          addr_err,
  input  logic          nmi_pulse,
  input  logic [1:0]    ch_req,
  input  logic [1:0]    ch_en,
  input  logic          xfer_done,
  output logic [1:0]    ch_gnt,
  output logic          err_irq
);
  logic             pr, ie;
  logic [NFLAG-1:0] flag, evt;

  assign evt[FL_NMI] = nmi_pulse;
  assign evt[FL_AE]  = addr_err;

  dmaop_reg #(.DW(DW)) i_reg (
    .clk(clk), .rst_n(rst_n), .stby(stby_full),
    .sel(reg_sel), .wr(reg_wr), .wdata(reg_wdata),
    .flag_evt(evt), .rdata(reg_rdata),
    .pr(pr), .ie(ie), .flag(flag)
  );

  dmaop_arb i_arb (
    .clk(clk), .rst_n(rst_n), .stby(stby_full), .hold(stby_mod),
    .block(|flag), .pr(pr), .req(ch_req), .en(ch_en),
    .done(xfer_done), .gnt(ch_gnt)
  );

  assign err_irq = ie && (|flag);

  // R11: interrupt follows enable and flags
  p_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq == (reg_rdata[0] && (reg_rdata[1] || reg_rdata[2])));
endmodule

// File: tb/test_dma_op_ctrl.sv
module test_dma_op_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        stby_full, stby_mod, reg_sel, reg_wr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        addr_err, nmi_pulse, xfer_done, err_irq;
  logic [1:0]  ch_req, ch_en, ch_gnt;

  int errors = 0;
  int checks = 0;
  bit ended  = 1'b0;

  always #10 clk = ~clk;

  dma_op_ctrl i_dma_op_ctrl (
    .clk(clk), .rst_n(rst_n), .stby_full(stby_full), .stby_mod(stby_mod),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .addr_err(addr_err), .nmi_pulse(nmi_pulse), .ch_req(ch_req), .ch_en(ch_en),
    .xfer_done(xfer_done), .ch_gnt(ch_gnt), .err_irq(err_irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(output logic [31:0] v);
    reg_sel = 1'b1; reg_wr = 1'b0;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_sel = 1'b0;
  endtask

  task automatic wr(input logic [31:0] v);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse_ae();
    addr_err = 1'b1; @(negedge clk); addr_err = 1'b0;
  endtask

  task automatic pulse_nmi();
    nmi_pulse = 1'b1; @(negedge clk); nmi_pulse = 1'b0;
  endtask

  task automatic fin();
    xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
  endtask

  task automatic clean();
    ch_req = '0; ch_en = '0;
    stby_full = 1'b1; @(negedge clk); stby_full = 1'b0;
  endtask

  task automatic t_reset();
    chk("R2 reset rdata", reg_rdata, 32'h0);
    chk("R2 reset gnt", {30'b0, ch_gnt}, 32'h0);
    chk("R11 reset irq", {31'b0, err_irq}, 32'h0);
  endtask

  task automatic t_regbits();
    logic [31:0] v;
    clean();
    wr(32'hFFFF_FFFF);
    rd(v); chk("R1 all-ones write reads 9", v, 32'h9);
    clean();
    wr(32'hFFFF_FFF0);
    rd(v); chk("R1 upper bits ignored", v, 32'h0);
  endtask

  task automatic t_stby();
    logic [31:0] v;
    clean();
    wr(32'h9); pulse_ae(); pulse_nmi();
    rd(v); chk("R2 before standby", v, 32'hF);
    clean();
    rd(v); chk("R2 full standby clears", v, 32'h0);
  endtask

  task automatic t_fixed();
    clean();
    ch_en = 2'b11; ch_req = 2'b11;
    @(negedge clk); chk("R3 tie goes to ch0", {30'b0, ch_gnt}, 32'h1);
    fin(); chk("R10 grant drops on done", {30'b0, ch_gnt}, 32'h0);
    @(negedge clk); chk("R3 ch0 again in fixed", {30'b0, ch_gnt}, 32'h1);
    fin(); ch_req = 2'b10;
    @(negedge clk); chk("R3 ch1 alone", {30'b0, ch_gnt}, 32'h2);
    fin(); ch_req = 2'b11; ch_en = 2'b10;
    @(negedge clk); chk("R10 enable masks ch0", {30'b0, ch_gnt}, 32'h2);
    fin(); ch_req = '0;
  endtask

  task automatic t_rr();
    clean();
    wr(32'h8);
    ch_en = 2'b11; ch_req = 2'b11;
    @(negedge clk); chk("R4 ch1 first", {30'b0, ch_gnt}, 32'h2);
    fin();
    @(negedge clk); chk("R4 rotate to ch0", {30'b0, ch_gnt}, 32'h1);
    fin();
    @(negedge clk); chk("R4 rotate back to ch1", {30'b0, ch_gnt}, 32'h2);
    fin(); ch_req = '0;
  endtask

  task automatic t_hold();
    clean();
    ch_en = 2'b11; ch_req = 2'b01;
    @(negedge clk); chk("R10 grant ch0", {30'b0, ch_gnt}, 32'h1);
    ch_req = 2'b00;
    repeat (3) @(negedge clk);
    chk("R10 held after request drop", {30'b0, ch_gnt}, 32'h1);
    fin(); chk("R10 released by done", {30'b0, ch_gnt}, 32'h0);
  endtask

  task automatic t_ae_block();
    logic [31:0] v;
    clean();
    pulse_ae();
    rd(v); chk("R6 flag set", v, 32'h4);
    ch_en = 2'b11; ch_req = 2'b11;
    repeat (3) @(negedge clk);
    chk("R6 no grant while flag set", {30'b0, ch_gnt}, 32'h0);
    rd(v); wr(32'h0);
    @(negedge clk); chk("R6 grant resumes after clear", {30'b0, ch_gnt}, 32'h1);
    fin(); ch_req = '0;
  endtask

  task automatic t_inflight();
    logic [31:0] v;
    clean();
    ch_en = 2'b11; ch_req = 2'b01;
    @(negedge clk); chk("R7 granted", {30'b0, ch_gnt}, 32'h1);
    pulse_ae();
    @(negedge clk); chk("R7 grant survives error", {30'b0, ch_gnt}, 32'h1);
    fin();
    @(negedge clk); chk("R7 no later grant", {30'b0, ch_gnt}, 32'h0);
    ch_req = '0;
    rd(v); wr(32'h0);
  endtask

  task automatic t_handshake();
    logic [31:0] v;
    clean();
    pulse_ae();
    wr(32'h0);
    rd(v); chk("R8 unarmed write keeps flag", v, 32'h4);
    wr(32'h0);
    rd(v); chk("R8 armed write clears", v, 32'h0);
    pulse_ae();
    wr(32'h0);
    rd(v); chk("R8 read of 0 does not arm", v, 32'h4);
    wr(32'h4);
    wr(32'h0);
    rd(v); chk("R8 any write disarms", v, 32'h4);
    wr(32'h0);
    wr(32'h6);
    rd(v); chk("R8 writing 1 never sets", v, 32'h0);
  endtask

  task automatic t_nmi();
    logic [31:0] v;
    clean();
    pulse_nmi();
    ch_en = 2'b11; ch_req = 2'b01;
    repeat (2) @(negedge clk);
    chk("R9 NMI blocks grant", {30'b0, ch_gnt}, 32'h0);
    rd(v); chk("R9 NMI flag reads bit1", v, 32'h2);
    wr(32'h0);
    @(negedge clk); chk("R9 grant after NMI clear", {30'b0, ch_gnt}, 32'h1);
    fin(); ch_req = '0;
  endtask

  task automatic t_mstby();
    logic [31:0] v;
    clean();
    wr(32'h8);
    stby_mod = 1'b1; ch_en = 2'b11; ch_req = 2'b11;
    repeat (2) @(negedge clk);
    chk("R5 no grant in module standby", {30'b0, ch_gnt}, 32'h0);
    stby_mod = 1'b0;
    rd(v); chk("R5 mode kept", v, 32'h8);
    chk("R5 rotating grant resumes on ch1", {30'b0, ch_gnt}, 32'h2);
    fin(); ch_req = '0;
  endtask

  task automatic t_irq();
    logic [31:0] v;
    clean();
    pulse_nmi();
    chk("R11 no irq when disabled", {31'b0, err_irq}, 32'h0);
    rd(v); wr(32'h1);
    chk("R11 enabled with no flag", {31'b0, err_irq}, 32'h0);
    pulse_ae();
    chk("R11 irq on error", {31'b0, err_irq}, 32'h1);
    rd(v); wr(32'h1);
    chk("R11 irq clears with flag", {31'b0, err_irq}, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    clean();
    pulse_ae();
    rd(v);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = '0; addr_err = 1'b1;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0; addr_err = 1'b0;
    rd(v); chk("R12 set wins over clear", v, 32'h4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; stby_full = 1'b0; stby_mod = 1'b0;
    reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    addr_err = 1'b0; nmi_pulse = 1'b0; xfer_done = 1'b0;
    ch_req = '0; ch_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regbits();
    t_stby();
    t_fixed();
    t_rr();
    t_hold();
    t_ae_block();
    t_inflight();
    t_handshake();
    t_nmi();
    t_mstby();
    t_irq();
    t_collide();
    ended = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule